// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to a few hundred pins. The default is 102 pins. The pins are arranged in 32-bit banks, and every register type has one word per bank. Software reads and writes those words over a plain 32-bit bus: a write strobe, an address, write data, and read data that is combinational from the address. The controller drives a value and an output enable for each pin. It resynchronizes every pin input through two flops, watches each synchronized input for edges, and combines every pending status bit into one registered interrupt line.

Several variants are chosen by parameter. The enable register can be left out, and every pin then counts as enabled. The edge-select register can be left out, and interrupts then follow a high input level instead of an edge. A fixed pin-to-bit permutation can be switched on; it applies to the output, direction, level, mask, status and edge-select registers. The enable register always stays indexed by logical pin number.

Top module: `pinbank_ctrl`

## Requirements
- R1: The address splits as follows. Bits [7:5] select the register: 0 enable, 1 output value, 2 direction, 3 input level (read-only), 4 interrupt mask, 5 pending status, 6 edge select. Bits [4:2] select the bank. Without remap, pin p is bit p mod 32 of bank p div 32. Register code 7, and any bank at or above the bank count, reads as zero and ignores writes.
- R2: Reset has these effects. Enable, output value, edge select and pending status are cleared. Every valid direction bit and every valid mask bit is set to 1. The interrupt output is 0 and no pin is driven.
- R3: A direction bit of 1 makes the pin an input, with pin_oe low. A direction bit of 0 on an enabled pin raises pin_oe, and pin_out then follows the output-value bit.
- R4: With the enable register present, a pin whose enable bit is 0 is never driven, and its edges never set status.
- R5: The input-level register returns each pin's input after two synchronizing flops, whatever the pin's direction. A change on a pin is visible to a read after the second rising clock edge.
- R6: An edge-select bit of 1 detects rising edges, and 0 detects falling edges. The status bit is set on the third rising clock edge after the pin input changes. The opposite edge sets nothing.
- R7: A mask bit of 1 stops that pin's edge from setting status.
- R8: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged. A new event in the same cycle wins over a clear.
- R9: Bits beyond the last existing pin read as 0 in every register and never become pending. With 102 pins, bank 3 has only bits 0 to 5.
- R10: irq_out is the OR of all status bits, registered. It rises one cycle after a status bit is set and falls one cycle after the last one is cleared.
- R11: Without the edge-select register, an enabled, unmasked pin that is held high sets its status bit every cycle, so a clear does not stick while the input stays high. The edge-select register then reads 0.
- R12: In remap mode, the mapping from pin to bit is as follows. Pins 0 to 27 use bits 4 to 31. Pins 28 to 33 have no bit and are never driven. Pins 34 to 97 use bit pin−2. Pins 98 to 101 use bit 101−pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 8 | Byte address: register code and bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| pin_in | input | NUM_PINS | Pin input levels, asynchronous |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong direction, enable or output bit shows on pin_oe or pin_out on the clock edge that completes the write. A wrong synchronizer depth moves the input-level read, the status set, or both, by one cycle away from the second and third edge after a pin change. A status bit that is set wrongly, cleared wrongly or left stuck reaches irq_out one cycle later. It also shows directly when the status word is read, including the bits past the last pin, which must stay zero.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int WORD_W   = 32;
  localparam int MAX_BITS = 256;

  typedef enum logic [2:0] {
    RG_ENA  = 3'd0,
    RG_OUT  = 3'd1,
    RG_DIR  = 3'd2,
    RG_LVL  = 3'd3,
    RG_MSK  = 3'd4,
    RG_PND  = 3'd5,
    RG_EDG  = 3'd6,
    RG_NONE = 3'd7
  } reg_sel_e;

  function automatic int bank_count(input int npins);
    return (npins + WORD_W - 1) / WORD_W;
  endfunction

  // register bit position -> logical pin, -1 when the bit carries no pin
  function automatic int bit_to_pin(input int b, input int remap, input int npins);
    int p;
    if (remap == 0)   p = b;
    else if (b <= 3)  p = 101 - b;
    else if (b <= 31) p = b - 4;
    else if (b <= 95) p = b + 2;
    else              p = -1;
    if (p >= npins || b >= bank_count(npins) * WORD_W) p = -1;
    return p;
  endfunction

  // logical pin -> register bit position, -1 when the pin has no bit
  function automatic int pin_to_bit(input int p, input int remap, input int npins);
    int b;
    if (remap == 0)    b = p;
    else if (p <= 27)  b = p + 4;
    else if (p <= 33)  b = -1;
    else if (p <= 97)  b = p - 2;
    else if (p <= 101) b = 101 - p;
    else               b = -1;
    if (p >= npins || b >= bank_count(npins) * WORD_W) b = -1;
    return b;
  endfunction

  function automatic logic [MAX_BITS-1:0] map_mask(input int remap, input int npins);
    logic [MAX_BITS-1:0] m;
    m = '0;
    for (int b = 0; b < MAX_BITS; b++) m[b] = (bit_to_pin(b, remap, npins) >= 0);
    return m;
  endfunction

  function automatic logic [MAX_BITS-1:0] pin_mask(input int npins);
    logic [MAX_BITS-1:0] m;
    m = '0;
    for (int b = 0; b < MAX_BITS; b++) m[b] = (b < npins);
    return m;
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int N = 102
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq #(
  parameter int NBITS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] hit,
  input  logic [NBITS-1:0] keep,
  output logic [NBITS-1:0] pend,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & keep) | hit;
      irq  <= |pend;
    end
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS   = 102,
  parameter int HAS_ENABLE = 1,
  parameter int HAS_EDGE   = 1,
  parameter int REMAP      = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  localparam int BANKS = bank_count(NUM_PINS);
  localparam int NBITS = BANKS * WORD_W;
  localparam int IDX_W = $clog2(NBITS);
  localparam logic [MAX_BITS-1:0] MAP_ALL = map_mask(REMAP, NUM_PINS);
  localparam logic [MAX_BITS-1:0] PIN_ALL = pin_mask(NUM_PINS);
  localparam logic [NBITS-1:0] MAP_MASK = MAP_ALL[NBITS-1:0];
  localparam logic [NBITS-1:0] PIN_MASK = PIN_ALL[NBITS-1:0];

  reg_sel_e         sel;
  logic [2:0]       bank_idx;
  logic             bank_ok;
  logic [IDX_W-1:0] word_base;
  logic             wr_ok;
  logic             pnd_wr_evt;

  logic [NBITS-1:0] en_q, out_q, dir_q, msk_q, edg_q;
  logic [NBITS-1:0] lvl_bits, rise_bits, fall_bits, enp_bits;
  logic [NBITS-1:0] trig_bits, hit_bits, pend_bits, pnd_keep;
  logic [NUM_PINS-1:0] sync_lvl, sync_rise, sync_fall;

  assign sel        = reg_sel_e'(bus_addr[7:5]);
  assign bank_idx   = bus_addr[4:2];
  assign bank_ok    = int'(bank_idx) < BANKS;
  assign word_base  = IDX_W'({bank_idx, 5'b00000});
  assign wr_ok      = bus_we && bank_ok;
  assign pnd_wr_evt = wr_ok && (sel == RG_PND);

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      out_q <= '0;
      dir_q <= MAP_MASK;
      msk_q <= MAP_MASK;
      edg_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        RG_ENA: if (HAS_ENABLE != 0)
                  en_q[word_base +: 32] <= bus_wdata & PIN_MASK[word_base +: 32];
        RG_OUT: out_q[word_base +: 32] <= bus_wdata & MAP_MASK[word_base +: 32];
        RG_DIR: dir_q[word_base +: 32] <= bus_wdata & MAP_MASK[word_base +: 32];
        RG_MSK: msk_q[word_base +: 32] <= bus_wdata & MAP_MASK[word_base +: 32];
        RG_EDG: if (HAS_EDGE != 0)
                  edg_q[word_base +: 32] <= bus_wdata & MAP_MASK[word_base +: 32];
        default: ;
      endcase
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bank_ok) begin
      case (sel)
        RG_ENA:  bus_rdata = en_q[word_base +: 32];
        RG_OUT:  bus_rdata = out_q[word_base +: 32];
        RG_DIR:  bus_rdata = dir_q[word_base +: 32];
        RG_LVL:  bus_rdata = lvl_bits[word_base +: 32];
        RG_MSK:  bus_rdata = msk_q[word_base +: 32];
        RG_PND:  bus_rdata = pend_bits[word_base +: 32];
        RG_EDG:  bus_rdata = edg_q[word_base +: 32];
        default: bus_rdata = '0;
      endcase
    end
  end

  // write-zero-to-clear mask for the status word
  always_comb begin
    pnd_keep = '1;
    if (pnd_wr_evt) pnd_keep[word_base +: 32] = bus_wdata;
  end

  pinbank_sync #(.N(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .lvl    (sync_lvl),
    .rise   (sync_rise),
    .fall   (sync_fall)
  );

  // logical pin -> pad outputs
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int B = pin_to_bit(p, REMAP, NUM_PINS);
    if (B >= 0) begin : g_map
      logic pin_en;
      if (HAS_ENABLE != 0) begin : g_en
        assign pin_en = en_q[p];
      end else begin : g_noen
        assign pin_en = 1'b1;
      end
      assign pin_out[p] = out_q[B];
      assign pin_oe[p]  = ~dir_q[B] & pin_en;
    end else begin : g_none
      assign pin_out[p] = 1'b0;
      assign pin_oe[p]  = 1'b0;
    end
  end

  // register bit -> pin events
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    localparam int LP = bit_to_pin(b, REMAP, NUM_PINS);
    if (LP >= 0) begin : g_map
      assign lvl_bits[b]  = sync_lvl[LP];
      assign rise_bits[b] = sync_rise[LP];
      assign fall_bits[b] = sync_fall[LP];
      if (HAS_ENABLE != 0) begin : g_en
        assign enp_bits[b] = en_q[LP];
      end else begin : g_noen
        assign enp_bits[b] = 1'b1;
      end
    end else begin : g_none
      assign lvl_bits[b]  = 1'b0;
      assign rise_bits[b] = 1'b0;
      assign fall_bits[b] = 1'b0;
      assign enp_bits[b]  = 1'b0;
    end
  end

  if (HAS_EDGE != 0) begin : g_edge
    assign trig_bits = (edg_q & rise_bits) | (~edg_q & fall_bits);
  end else begin : g_level
    assign trig_bits = lvl_bits;
  end

  assign hit_bits = trig_bits & enp_bits & ~msk_q;

  pinbank_irq #(.NBITS(NBITS)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit_bits),
    .keep  (pnd_keep),
    .pend  (pend_bits),
    .irq   (irq_out)
  );
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int NBITS = 128,
  parameter int NPINS = 102
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             irq_out,
  input logic             pnd_wr_evt,
  input logic [NBITS-1:0] pend_bits,
  input logic [NBITS-1:0] hit_bits,
  input logic [NPINS-1:0] pin_oe
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq_out && pin_oe == '0)); // R2

  AST_OE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != $past(pin_oe)) |-> $past(bus_we)); // R3

  AST_PEND_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_bits & ~$past(pend_bits) & ~$past(hit_bits)) == '0)); // R6

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_bits) & ~pend_bits) != '0) |-> $past(pnd_wr_evt)); // R8

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_bits) |=> irq_out); // R10

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend_bits) |=> !irq_out); // R10
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NBITS(NBITS), .NPINS(NUM_PINS)) u_chk (.*);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 102;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [NP-1:0] pins = '0;
  logic [31:0]   rd_a, rd_m, rd_l;
  logic [NP-1:0] out_a, oe_a, out_m, oe_m, out_l, oe_l;
  logic          irq_a, irq_m, irq_l;
  int            ntests = 0;
  int            nfail = 0;
  bit            finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pin_in(pins),
    .pin_out(out_a), .pin_oe(oe_a), .irq_out(irq_a));

  pinbank_ctrl #(.REMAP(1)) uut_map (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_m), .pin_in(pins),
    .pin_out(out_m), .pin_oe(oe_m), .irq_out(irq_m));

  pinbank_ctrl #(.HAS_EDGE(0)) uut_lvl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_l), .pin_in(pins),
    .pin_out(out_l), .pin_oe(oe_l), .irq_out(irq_l));

  // register codes as listed in R1
  localparam logic [2:0] A_ENA = 3'd0, A_OUT = 3'd1, A_DIR = 3'd2, A_LVL = 3'd3,
                         A_MSK = 3'd4, A_PND = 3'd5, A_EDG = 3'd6, A_NONE = 3'd7;

  function automatic logic [7:0] adr(input logic [2:0] code, input int bank);
    return {code, 3'(bank), 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] code, input int bank, input logic [31:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = adr(code, bank); bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int which, input logic [2:0] code, input int bank,
                    input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus_addr = adr(code, bank);
    #1;
    v = (which == 0) ? rd_a : (which == 1) ? rd_m : rd_l;
    chk(req, v, exp);
  endtask

  task automatic do_reset();
    pins = '0;
    bus_we = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    rd(0, A_DIR, 0, 32'hffff_ffff, "R2 dir bank0");
    rd(0, A_DIR, 3, 32'h0000_003f, "R9 dir bank3");
    rd(0, A_MSK, 3, 32'h0000_003f, "R2 msk bank3");
    rd(0, A_OUT, 1, 32'h0, "R2 out");
    rd(0, A_PND, 0, 32'h0, "R2 pend");
    chk("R2 irq", {31'b0, irq_a}, 32'h0);
    chk("R2 oe", {31'b0, |oe_a}, 32'h0);
    rd(0, A_NONE, 0, 32'h0, "R1 unmapped code");
    rd(0, A_DIR, 5, 32'h0, "R1 bank beyond range");
  endtask

  task automatic t_output();
    do_reset();
    wr(A_ENA, 0, 32'h0000_0060);
    wr(A_DIR, 0, ~32'h0000_00a0);
    wr(A_OUT, 0, 32'h0000_00a0);
    chk("R3 oe pin5", {31'b0, oe_a[5]}, 32'h1);
    chk("R3 out pin5", {31'b0, out_a[5]}, 32'h1);
    chk("R3 input pin6", {31'b0, oe_a[6]}, 32'h0);
    chk("R4 disabled pin7", {31'b0, oe_a[7]}, 32'h0);
    wr(A_ENA, 1, 32'h0000_0100);
    wr(A_DIR, 1, ~32'h0000_0100);
    wr(A_OUT, 1, 32'h0000_0100);
    chk("R1 pin40 oe", {31'b0, oe_a[40]}, 32'h1);
    chk("R1 pin40 out", {31'b0, out_a[40]}, 32'h1);
    wr(A_OUT, 3, 32'hffff_ffff);
    rd(0, A_OUT, 3, 32'h0000_003f, "R9 out bank3");
    wr(A_ENA, 3, 32'hffff_ffff);
    rd(0, A_ENA, 3, 32'h0000_003f, "R9 ena bank3");
  endtask

  task automatic t_level_read();
    do_reset();
    wr(A_DIR, 0, ~32'h0000_0020);
    wr(A_OUT, 0, 32'h0000_0020);
    pins[70] = 1'b1;
    pins[5] = 1'b1;
    step(1);
    rd(0, A_LVL, 2, 32'h0, "R5 one edge");
    step(1);
    rd(0, A_LVL, 2, 32'h0000_0040, "R5 pin70");
    rd(0, A_LVL, 0, 32'h0000_0020, "R5 output pin reads input");
    wr(A_LVL, 0, 32'h0);
    rd(0, A_LVL, 0, 32'h0000_0020, "R1 level read-only");
  endtask

  task automatic t_edge();
    do_reset();
    wr(A_ENA, 0, 32'h0000_000a);
    wr(A_MSK, 0, ~32'h0000_000a);
    wr(A_EDG, 0, 32'h0000_0008);
    pins[3] = 1'b1;
    step(2);
    rd(0, A_PND, 0, 32'h0, "R6 not yet");
    step(1);
    rd(0, A_PND, 0, 32'h0000_0008, "R6 rising");
    chk("R10 irq delayed", {31'b0, irq_a}, 32'h0);
    step(1);
    chk("R10 irq up", {31'b0, irq_a}, 32'h1);
    wr(A_PND, 0, 32'hffff_ffff);
    rd(0, A_PND, 0, 32'h0000_0008, "R8 write one keeps");
    wr(A_PND, 0, ~32'h0000_0008);
    rd(0, A_PND, 0, 32'h0, "R8 write zero clears");
    chk("R10 irq lags clear", {31'b0, irq_a}, 32'h1);
    step(1);
    chk("R10 irq down", {31'b0, irq_a}, 32'h0);
    wr(A_EDG, 0, 32'h0);
    pins[3] = 1'b0;
    step(3);
    rd(0, A_PND, 0, 32'h0000_0008, "R6 falling");
    wr(A_PND, 0, 32'h0);
    pins[1] = 1'b1;
    step(5);
    rd(0, A_PND, 0, 32'h0, "R6 rising ignored in falling mode");
    chk("R6 no irq", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_mask();
    do_reset();
    wr(A_ENA, 0, 32'h0000_0008);
    wr(A_EDG, 0, 32'h0000_0008);
    pins[3] = 1'b1;
    step(5);
    rd(0, A_PND, 0, 32'h0, "R7 masked");
    chk("R7 no irq", {31'b0, irq_a}, 32'h0);
    wr(A_MSK, 0, ~32'h0000_0008);
    wr(A_ENA, 0, 32'h0);
    wr(A_EDG, 0, 32'h0);
    pins[3] = 1'b0;
    step(5);
    rd(0, A_PND, 0, 32'h0, "R4 disabled pin no status");
  endtask

  task automatic t_top_bank();
    do_reset();
    wr(A_ENA, 3, 32'hffff_ffff);
    wr(A_MSK, 3, 32'h0);
    wr(A_EDG, 3, 32'hffff_ffff);
    rd(0, A_EDG, 3, 32'h0000_003f, "R9 edge bank3");
    for (int p = 96; p < NP; p++) pins[p] = 1'b1;
    step(3);
    rd(0, A_PND, 3, 32'h0000_003f, "R9 only valid status bits");
  endtask

  task automatic t_level_mode();
    do_reset();
    wr(A_ENA, 0, 32'h0000_0400);
    wr(A_MSK, 0, ~32'h0000_0400);
    wr(A_EDG, 0, 32'hffff_ffff);
    rd(2, A_EDG, 0, 32'h0, "R11 edge reg absent");
    rd(0, A_EDG, 0, 32'hffff_ffff, "R1 edge reg present");
    pins[10] = 1'b1;
    step(3);
    rd(2, A_PND, 0, 32'h0000_0400, "R11 level sets");
    wr(A_PND, 0, ~32'h0000_0400);
    rd(2, A_PND, 0, 32'h0000_0400, "R11 clear while high");
    pins[10] = 1'b0;
    step(3);
    wr(A_PND, 0, 32'h0);
    rd(2, A_PND, 0, 32'h0, "R11 clear after low");
  endtask

  task automatic t_remap();
    do_reset();
    rd(1, A_DIR, 3, 32'h0, "R12 bank3 empty");
    rd(1, A_DIR, 0, 32'hffff_ffff, "R12 bank0 full");
    pins[0] = 1'b1;
    pins[99] = 1'b1;
    pins[50] = 1'b1;
    step(2);
    rd(1, A_LVL, 0, 32'h0000_0014, "R12 pins 0 and 99");
    rd(1, A_LVL, 1, 32'h0001_0000, "R12 pin50");
    wr(A_ENA, 0, 32'h4000_0001);
    wr(A_DIR, 0, ~32'h0000_0010);
    wr(A_OUT, 0, 32'h0000_0010);
    chk("R12 pin0 oe", {31'b0, oe_m[0]}, 32'h1);
    chk("R12 pin0 out", {31'b0, out_m[0]}, 32'h1);
    wr(A_DIR, 0, 32'h0);
    chk("R12 pin30 never driven", {31'b0, oe_m[30]}, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    ntests++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #2 rst_n = 1'b0;
    t_reset();
    t_output();
    t_level_read();
    t_edge();
    t_mask();
    t_top_bank();
    t_level_mode();
    t_remap();
    summary();
  end
endmodule